// File: doc/BRIEF.md
# Triggered Time-Division Debug Serializer

This block carries a wide internal probe bus off the device over a narrow group of debug pins. A slow-rate sample strobe marks each new probe word. The block latches the word into a holding register and then drives it out as equal-width slices, one slice per fast clock cycle, least significant slice first. A two-bit select picks how many slices make up one word: one, two or four. An external receiver rebuilds each word by joining consecutive slices. A marker pin is high on the first slice of every word, so the receiver always knows where a word begins.

Nothing reaches the pins until a trigger fires. The trigger compares each full-width sampled word against a pattern, under a mask. An arm input starts the search. Once the trigger fires it stays latched until the next arm pulse. The word that matched is the first word streamed. All logic runs on the fast clock, and the strobe is a one-cycle pulse in that domain. For back-to-back operation the strobe period should equal the number of slices.

Top module: `tdm_dbg_serializer`

## Requirements
- R1: While reset is applied and after it is released, with no arm pulse, dbg_valid_o, dbg_mark_o and every bit of dbg_pins_o are 0.
- R2: A trigger fires at a strobe cycle, while armed, when ((probe_i XOR trig_pat_i) AND trig_mask_i) is all zeros. The word sampled at that strobe is the first word sent.
- R3: A fired trigger stays fired across any number of later words until trig_arm_i is pulsed. An arm pulse clears it, so streaming stops from the cycle after the arm edge and resumes only on a new match.
- R4: While the trigger has not fired, dbg_valid_o and dbg_mark_o are 0 and dbg_pins_o is all zeros, whatever the probe carries.
- R5: In the N cycles after a strobe edge, slice k appears in cycle k+1 (k = 0..N-1). Slice k carries probe bits [(k+1)*W/N-1 : k*W/N] on pins [W/N-1:0], and the pins above W/N are 0.
- R6: ratio_sel_i encodes the slices per word: 0 gives 1, 1 gives 2, and both 2 and 3 give 4.
- R7: When dbg_valid_o is high, dbg_mark_o is high exactly on slice 0 of a word.
- R8: ratio_sel_i is sampled only at a strobe. A change between strobes does not alter the slicing of the word in flight.
- R9: The probe word is captured at the strobe. A change on probe_i between strobes does not alter the slices being sent.
- R10: If no strobe follows the last slice, dbg_valid_o drops to 0. A strobe that arrives before the last slice abandons the rest of the old word and starts the new one at slice 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| probe_i | input | PROBE_W | Internal debug bus under observation |
| smp_stb_i | input | 1 | One-cycle pulse marking a new probe sample |
| ratio_sel_i | input | 2 | Slices per word: 0 gives 1, 1 gives 2, 2 or 3 gives 4 |
| trig_arm_i | input | 1 | Pulse that clears the trigger and starts a new search |
| trig_pat_i | input | PROBE_W | Trigger compare pattern |
| trig_mask_i | input | PROBE_W | Trigger care mask, 1 means the bit is compared |
| dbg_pins_o | output | PROBE_W | Slice output; only the low PROBE_W/N bits are used |
| dbg_mark_o | output | 1 | High on the first slice of each word |
| dbg_valid_o | output | 1 | High while a triggered slice is on the pins |

## Verification
Each internal state has its own visible symptom.
- A wrong slice counter puts bits from the wrong part of the word on the pins, or moves the marker. This shows in the first cycle after the strobe, or in the cycle after that.
- A ratio register that follows the select between strobes changes the slice width partway through a word. This is exposed within one cycle by the bench, which changes the select on every non-strobe cycle.
- A trigger flag that fails to latch, or that ignores the mask, opens or closes dbg_valid_o one whole word early or late.
The reference model predicts every output on every cycle, so each of these faults shows up as a miscompare in the cycle it first happens.

// File: rtl/tdm_dbg_pkg.sv
package tdm_dbg_pkg;

  // number of supported slicing modes: 1, 2 and 4 slices per word
  localparam int NUM_MODES = 3;
  localparam int SLC_W     = 2;

  typedef enum logic [1:0] {
    RATIO_ONE  = 2'd0,
    RATIO_TWO  = 2'd1,
    RATIO_FOUR = 2'd2,
    RATIO_ALT4 = 2'd3
  } ratio_e;

  // log2 of slices per word
  function automatic logic [1:0] mode_log2(input logic [1:0] code);
    case (ratio_e'(code))
      RATIO_ONE:  return 2'd0;
      RATIO_TWO:  return 2'd1;
      default:    return 2'd2;
    endcase
  endfunction

  // index of the final slice in a word
  function automatic logic [SLC_W-1:0] last_slice(input logic [1:0] lg);
    case (lg)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/tdm_trig.sv
module tdm_trig #(
  parameter int PROBE_W = 8
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               arm_i,
  input  logic               stb_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [PROBE_W-1:0] pat_i,
  input  logic [PROBE_W-1:0] mask_i,
  output logic               fired_o
);

  logic armed_q, armed_d;
  logic fired_q, fired_d;
  logic hit;

  assign hit = ((probe_i ^ pat_i) & mask_i) == '0;

  always_comb begin
    armed_d = armed_q;
    fired_d = fired_q;
    if (arm_i) begin
      armed_d = 1'b1;
      fired_d = 1'b0;
    end else if (stb_i && armed_q && hit) begin
      armed_d = 1'b0;
      fired_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      fired_q <= fired_d;
    end
  end

  assign fired_o = fired_q;

  // R3: fired state is sticky until re-armed
  p_fire_sticky_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    fired_q && !arm_i |=> fired_q);

  // R3: an arm pulse always clears the fired state
  p_arm_clears_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    arm_i |=> !fired_q);

  // R2: firing needs an armed search and a strobe
  p_fire_cause_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !fired_q && !(armed_q && stb_i) |=> !fired_q);

endmodule

// File: rtl/tdm_slicer.sv
module tdm_slicer
  import tdm_dbg_pkg::*;
#(
  parameter int PROBE_W = 8
) (
  input  logic               clk,
  input  logic               rst_sn,
  input  logic               stb_i,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic [1:0]         ratio_sel_i,
  output logic [PROBE_W-1:0] hold_o,
  output logic [1:0]         lg_o,
  output logic [SLC_W-1:0]   slc_o,
  output logic               busy_o
);

  logic [PROBE_W-1:0] hold_q;
  logic [1:0]         lg_q, lg_d;
  logic [SLC_W-1:0]   slc_q, slc_d;
  logic               busy_q, busy_d;

  // next-state for the slice sequencer
  always_comb begin
    lg_d   = lg_q;
    slc_d  = slc_q;
    busy_d = busy_q;
    if (stb_i) begin
      lg_d   = mode_log2(ratio_sel_i);
      slc_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (slc_q == last_slice(lg_q)) begin
        slc_d  = '0;
        busy_d = 1'b0;
      end else begin
        slc_d  = slc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      lg_q   <= '0;
      slc_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      lg_q   <= lg_d;
      slc_q  <= slc_d;
      busy_q <= busy_d;
    end
  end

  // word holding register with explicit clock enable
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      hold_q <= '0;
    end else if (stb_i) begin
      hold_q <= probe_i;
    end
  end

  assign hold_o = hold_q;
  assign lg_o   = lg_q;
  assign slc_o  = slc_q;
  assign busy_o = busy_q;

  // R8: the slicing mode cannot move while a word is in flight
  p_ratio_locked_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    !stb_i |=> $stable(lg_q));

  // R9: the held word changes only at a strobe
  p_word_held_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !stb_i |=> $stable(hold_q));

  // R5: the slice index stays inside the word
  p_slice_bound_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_q |-> (slc_q <= last_slice(lg_q)));

  // R10: a strobe always restarts at slice zero
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    stb_i |=> busy_q && slc_q == '0);

endmodule

// File: rtl/tdm_pinmux.sv
module tdm_pinmux
  import tdm_dbg_pkg::*;
#(
  parameter int PROBE_W = 8
) (
  input  logic [PROBE_W-1:0] hold_i,
  input  logic [1:0]         lg_i,
  input  logic [SLC_W-1:0]   slc_i,
  input  logic               en_i,
  output logic [PROBE_W-1:0] pins_o,
  output logic               mark_o
);

  logic [PROBE_W-1:0] mode_data [NUM_MODES];
  logic [PROBE_W-1:0] pick;

  // one slice selector per slicing mode
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int               SW       = PROBE_W >> m;
    localparam logic [SLC_W-1:0] IDX_MASK = SLC_W'((1 << m) - 1);
    logic [SLC_W-1:0] idx;
    assign idx = slc_i & IDX_MASK;
    always_comb begin
      mode_data[m]         = '0;
      mode_data[m][SW-1:0] = hold_i[int'(idx)*SW +: SW];
    end
  end

  always_comb begin
    pick = '0;
    for (int m = 0; m < NUM_MODES; m++) begin
      if (lg_i == 2'(m)) pick = mode_data[m];
    end
  end

  assign pins_o = en_i ? pick : '0;
  assign mark_o = en_i && (slc_i == '0);

endmodule

// File: rtl/tdm_dbg_serializer.sv
module tdm_dbg_serializer
  import tdm_dbg_pkg::*;
#(
  parameter int PROBE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               smp_stb_i,
  input  logic [1:0]         ratio_sel_i,
  input  logic               trig_arm_i,
  input  logic [PROBE_W-1:0] trig_pat_i,
  input  logic [PROBE_W-1:0] trig_mask_i,
  output logic [PROBE_W-1:0] dbg_pins_o,
  output logic               dbg_mark_o,
  output logic               dbg_valid_o
);

  localparam int HALF_W = PROBE_W / 2;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic               fired;
  logic [PROBE_W-1:0] hold;
  logic [1:0]         lg;
  logic [SLC_W-1:0]   slc;
  logic               busy;
  logic               stream_en;

  tdm_trig #(.PROBE_W(PROBE_W)) u_trig (
    .clk     (clk),
    .rst_sn  (rst_sn),
    .arm_i   (trig_arm_i),
    .stb_i   (smp_stb_i),
    .probe_i (probe_i),
    .pat_i   (trig_pat_i),
    .mask_i  (trig_mask_i),
    .fired_o (fired)
  );

  tdm_slicer #(.PROBE_W(PROBE_W)) u_slicer (
    .clk         (clk),
    .rst_sn      (rst_sn),
    .stb_i       (smp_stb_i),
    .probe_i     (probe_i),
    .ratio_sel_i (ratio_sel_i),
    .hold_o      (hold),
    .lg_o        (lg),
    .slc_o       (slc),
    .busy_o      (busy)
  );

  assign stream_en = fired && busy;

  tdm_pinmux #(.PROBE_W(PROBE_W)) u_pinmux (
    .hold_i (hold),
    .lg_i   (lg),
    .slc_i  (slc),
    .en_i   (stream_en),
    .pins_o (dbg_pins_o),
    .mark_o (dbg_mark_o)
  );

  assign dbg_valid_o = stream_en;

  // R7: the cycle after a strobe always opens a word with the marker
  p_first_slice_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(smp_stb_i) && dbg_valid_o |-> dbg_mark_o);

  // R4: with the trigger unfired, the pins stay quiet
  p_quiet_unfired_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !fired |-> dbg_pins_o == '0 && !dbg_mark_o && !dbg_valid_o);

  // R5: in two-slice mode the upper pins carry nothing
  p_narrow_two_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    dbg_valid_o && lg == 2'd1 |-> dbg_pins_o[PROBE_W-1:HALF_W] == '0);

  // R10: with no new strobe, a single-slice word occupies exactly one cycle
  p_single_drop_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    dbg_valid_o && lg == 2'd0 && !smp_stb_i |=> !dbg_valid_o);

endmodule

// File: tb/sim_tdm_dbg_serializer.sv
module sim_tdm_dbg_serializer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] probe;
  logic         stb;
  logic [1:0]   ratio;
  logic         arm;
  logic [W-1:0] pat;
  logic [W-1:0] mask;
  logic [W-1:0] pins;
  logic         mark;
  logic         valid;

  always #2 clk = ~clk;

  tdm_dbg_serializer #(.PROBE_W(W)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_i     (probe),
    .smp_stb_i   (stb),
    .ratio_sel_i (ratio),
    .trig_arm_i  (arm),
    .trig_pat_i  (pat),
    .trig_mask_i (mask),
    .dbg_pins_o  (pins),
    .dbg_mark_o  (mark),
    .dbg_valid_o (valid)
  );

  int    n_vec  = 0;
  int    n_bad  = 0;
  string cur_req = "R1";
  bit    done   = 1'b0;

  // behavioural reference: a queue of pending slices per word
  int m_data[$];
  bit m_mark[$];
  bit m_armed;
  bit m_fired;

  function automatic int nslices(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data.delete();
      m_mark.delete();
      m_armed = 0;
      m_fired = 0;
    end else begin
      if (arm) begin
        m_armed = 1;
        m_fired = 0;
      end else if (stb && m_armed && (((probe ^ pat) & mask) == 0)) begin
        m_fired = 1;
        m_armed = 0;
      end
      if (stb) begin
        int n;
        int sw;
        n  = nslices(ratio);
        sw = W / n;
        m_data.delete();
        m_mark.delete();
        for (int k = 0; k < n; k++) begin
          m_data.push_back((int'(probe) >> (k * sw)) & ((1 << sw) - 1));
          m_mark.push_back(k == 0);
        end
      end else if (m_data.size() > 0) begin
        void'(m_data.pop_front());
        void'(m_mark.pop_front());
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit exp_v;
      bit exp_m;
      int exp_p;
      exp_v = m_fired && (m_data.size() > 0);
      exp_p = exp_v ? m_data[0] : 0;
      exp_m = exp_v ? m_mark[0] : 1'b0;
      n_vec++;
      if (valid !== exp_v || mark !== exp_m || int'(pins) != exp_p || $isunknown(pins)) begin
        n_bad++;
        $display("FAIL %s t=%0t pins/mark/valid actual %h/%b/%b expected %h/%b/%b",
                 cur_req, $time, pins, mark, valid, exp_p[W-1:0], exp_m, exp_v);
      end
    end
  end

  // one word: strobe, then slices-1+extra cycles with scrambled probe and select (R8, R9)
  task automatic word(input logic [W-1:0] d, input logic [1:0] rc, input int extra);
    @(negedge clk);
    probe = d;
    ratio = rc;
    stb   = 1'b1;
    for (int k = 1; k < nslices(rc) + extra; k++) begin
      @(negedge clk);
      stb   = 1'b0;
      probe = W'($urandom);
      ratio = 2'($urandom);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      stb   = 1'b0;
      probe = W'($urandom);
      ratio = 2'($urandom);
    end
  endtask

  task automatic do_arm();
    @(negedge clk);
    stb = 1'b0;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired in %s", cur_req);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    probe = '0;
    stb   = 1'b0;
    ratio = 2'd1;
    arm   = 1'b0;
    pat   = 8'hA5;
    mask  = 8'hF0;
    repeat (3) @(negedge clk);
    // R1: explicit reset-state check
    n_vec++;
    if (valid !== 1'b0 || mark !== 1'b0 || pins !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual %h/%b/%b expected 00/0/0", pins, mark, valid);
    end
    rst_n = 1'b1;
    idle(4);

    // R4: words flow through the slicer but the trigger was never armed
    cur_req = "R4";
    word(8'hA5, 2'd1, 0);
    word(8'h3C, 2'd2, 0);
    word(8'hFF, 2'd0, 0);

    // R2: arm, send non-matching words, then a match on the upper nibble only
    cur_req = "R2";
    do_arm();
    word(8'h15, 2'd1, 0);
    word(8'hB5, 2'd1, 0);
    word(8'hA3, 2'd1, 0);

    // R3, R5, R7: stay fired over several 2:1 words
    cur_req = "R5";
    for (int i = 0; i < 6; i++) word(W'($urandom), 2'd1, 0);

    // R6: every ratio code, with the select scrambled mid-word (R8)
    cur_req = "R6";
    for (int i = 0; i < 4; i++) word(W'($urandom), 2'd0, 0);
    for (int i = 0; i < 4; i++) word(W'($urandom), 2'd2, 0);
    for (int i = 0; i < 4; i++) word(W'($urandom), 2'd3, 0);
    cur_req = "R8";
    for (int i = 0; i < 12; i++) word(W'($urandom), 2'($urandom), 0);

    // R10: gaps after words, and early strobes that cut a word short
    cur_req = "R10";
    word(8'h96, 2'd2, 3);
    word(8'h5A, 2'd1, 2);
    word(8'hC3, 2'd2, -2);
    word(8'h81, 2'd2, -1);
    word(8'h7E, 2'd1, -1);
    idle(5);

    // R3: re-arm stops streaming until the next match
    cur_req = "R3";
    pat  = 8'h00;
    mask = 8'h0F;
    do_arm();
    word(8'h11, 2'd2, 0);
    word(8'h2F, 2'd1, 0);
    word(8'hE0, 2'd1, 0);
    word(8'h44, 2'd2, 0);
    mask = 8'h00;
    do_arm();
    word(8'h99, 2'd0, 0);
    word(8'h12, 2'd2, 1);

    // long mixed run
    cur_req = "R9";
    for (int i = 0; i < 40; i++) word(W'($urandom), 2'($urandom), int'($urandom_range(0, 2)));
    idle(6);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule